// File: doc/BRIEF.md
# Dual-Lane Signed Integer to Double Converter

This block turns a 128-bit source vector into a 128-bit result. The source holds two signed 64-bit integers, and each becomes an IEEE 754 binary64 value. A single 2-bit rounding-mode input applies to both lanes. The caller pulses `start` for one cycle. Exactly one cycle later the block presents the converted vector, the target-register write enable, the new values of the sticky inexact and summary flags, and a trap indication.

The flags are computed in lane order. Lane 0 is converted first and lane 1 second, and the inexact indication is cleared at the start of each lane. When inexact traps are enabled and either lane rounds, the target register is left untouched for both lanes, but the flags are still updated. If the unit is disabled when `start` arrives, the block raises only the unavailable trap: it produces no result, asks for no writeback and updates no flag.

Top module: `dualIntToDbl`

## Requirements
- R1: Lane 0 is `srcVec[63:0]` and lane 1 is `srcVec[127:64]`. Each lane is a two's-complement integer, and its binary64 encoding appears in the same bit positions of `resultVec` one cycle after a `start` with `unitEn`=1.
- R2: `rndMode` is shared by both lanes. The encodings are 00 nearest with ties to even, 01 toward zero, 10 toward +infinity and 11 toward −infinity.
- R3: Magnitudes up to 2^53 convert exactly and are not inexact. Zero gives all-zero bits (+0.0), and −2^63 gives 0xC3E0000000000000 exactly.
- R4: When rounding carries out of the fraction, the exponent is incremented. For example, 2^63−1 to nearest gives 0x43E0000000000000 and is inexact.
- R5: On a converted `start`, `xxNew` equals `xxIn` OR the inexact result of either lane, and `flagWe` is 1.
- R6: `fxNew` becomes 1 only when `xxIn` is 0 and some lane is inexact. Otherwise `fxNew` equals `fxIn`.
- R7: When `inexEn` is 1 and either lane is inexact, `resWe` is 0 while `flagWe` and the flags still update. Otherwise a converted `start` gives `resWe`=1.
- R8: A `start` with `unitEn`=0 gives `trapUnavail`=1 one cycle later, with `resWe`=0 and `flagWe`=0, and `resultVec` unchanged.
- R9: Without a `start` in the previous cycle, `resWe`, `flagWe` and `trapUnavail` are 0.
- R10: During and after reset, with no `start`, `resultVec` is 0 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation strobe |
| unitEn | input | 1 | Vector unit enabled |
| rndMode | input | 2 | Rounding mode shared by both lanes |
| inexEn | input | 1 | Inexact exception enable |
| xxIn | input | 1 | Current sticky inexact flag |
| fxIn | input | 1 | Current exception summary flag |
| srcVec | input | 128 | Two signed 64-bit integers |
| resultVec | output | 128 | Two binary64 results |
| resWe | output | 1 | Target register write enable |
| flagWe | output | 1 | Flag update strobe |
| xxNew | output | 1 | Updated sticky inexact flag |
| fxNew | output | 1 | Updated summary flag |
| trapUnavail | output | 1 | Unit-unavailable trap |

## Verification
On every cycle, the assertions check the control behaviour. Strobes appear only after a `start`. The trap excludes writeback and flag updates and leaves the result untouched. Sticky flags are never cleared. The summary flag stays put when the inexact flag was already set. An inexact trap that is newly raised and enabled blocks the write. Whether each rounded encoding is right, including ties, carry into the exponent, and the −2^63 and 2^53 corners, shows only in the bench's sweeps against its arithmetic model under all four rounding modes.

// File: rtl/i2dPkg.sv
package i2dPkg;
  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rndMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
  } ctlStrobe_t;
endpackage

// File: rtl/i2dLane.sv
module i2dLane #(
  parameter int INT_W  = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [INT_W-1:0]          intIn,
  input  i2dPkg::rndMode_e          rm,
  output logic [EXP_W+FRAC_W:0]     dblOut,
  output logic                      inexact
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int LOW_W   = INT_W - 1 - FRAC_W;
  localparam int LZC_W   = $clog2(INT_W);
  localparam int TOP_EXP = BIAS + INT_W - 1;

  logic             sgn;
  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [LZC_W-1:0] lzc;
  logic [FRAC_W-1:0] frac;
  logic             guardBit;
  logic             stickyBit;
  logic             roundUp;
  logic [FRAC_W:0]  sum;
  logic             carry;
  logic [EXP_W-1:0] expVal;

  always_comb begin
    sgn = intIn[INT_W-1];
    mag = sgn ? (~intIn + 1'b1) : intIn;
    lzc = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lzc = LZC_W'(INT_W - 1 - i);
    end
    norm      = mag << lzc;
    frac      = norm[INT_W-2 -: FRAC_W];
    guardBit  = norm[LOW_W-1];
    stickyBit = |norm[LOW_W-2:0];
    inexact   = guardBit | stickyBit;
    unique case (rm)
      i2dPkg::RM_NEAR_EVEN: roundUp = guardBit & (stickyBit | frac[0]);
      i2dPkg::RM_TO_ZERO:   roundUp = 1'b0;
      i2dPkg::RM_TO_POS:    roundUp = inexact & ~sgn;
      default:              roundUp = inexact & sgn;
    endcase
    sum    = {1'b0, frac} + {{FRAC_W{1'b0}}, roundUp};
    carry  = sum[FRAC_W];
    expVal = EXP_W'(TOP_EXP - int'(lzc) + int'(carry));
    if (norm[INT_W-1]) dblOut = {sgn, expVal, sum[FRAC_W-1:0]};
    else               dblOut = '0;
  end
endmodule

// File: rtl/i2dDatapath.sv
module i2dDatapath #(
  parameter int LANES  = 2,
  parameter int INT_W  = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  i2dPkg::ctlStrobe_t       strobe,
  input  logic [1:0]               rndMode,
  input  logic [LANES*INT_W-1:0]   srcVec,
  output logic [LANES-1:0]         laneInexact,
  output logic [LANES*INT_W-1:0]   resultVec
);
  localparam int VEC_W = LANES * INT_W;

  logic [VEC_W-1:0] laneRes;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    i2dLane #(.INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) uLane (
      .intIn   (srcVec[g*INT_W +: INT_W]),
      .rm      (i2dPkg::rndMode_e'(rndMode)),
      .dblOut  (laneRes[g*INT_W +: INT_W]),
      .inexact (laneInexact[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resultVec <= '0;
    else if (strobe.load) resultVec <= laneRes;
  end
endmodule

// File: rtl/i2dControl.sv
module i2dControl #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               unitEn,
  input  logic               inexEn,
  input  logic               xxIn,
  input  logic               fxIn,
  input  logic [LANES-1:0]   laneInexact,
  output i2dPkg::ctlStrobe_t strobe,
  output logic               resWe,
  output logic               flagWe,
  output logic               xxNew,
  output logic               fxNew,
  output logic               trapUnavail
);
  logic anyInexact;
  logic exFlag;

  always_comb begin
    anyInexact  = |laneInexact;
    exFlag      = inexEn & anyInexact;
    strobe.load = start & unitEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resWe       <= 1'b0;
      flagWe      <= 1'b0;
      trapUnavail <= 1'b0;
      xxNew       <= 1'b0;
      fxNew       <= 1'b0;
    end else begin
      resWe       <= strobe.load & ~exFlag;
      flagWe      <= strobe.load;
      trapUnavail <= start & ~unitEn;
      if (strobe.load) begin
        // in lane order, only the first inexact lane can flip XX 0->1
        xxNew <= xxIn | anyInexact;
        fxNew <= fxIn | (anyInexact & ~xxIn);
      end
    end
  end
endmodule

// File: rtl/dualIntToDbl.sv
module dualIntToDbl #(
  parameter int LANES  = 2,
  parameter int INT_W  = 64,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   unitEn,
  input  logic [1:0]             rndMode,
  input  logic                   inexEn,
  input  logic                   xxIn,
  input  logic                   fxIn,
  input  logic [LANES*INT_W-1:0] srcVec,
  output logic [LANES*INT_W-1:0] resultVec,
  output logic                   resWe,
  output logic                   flagWe,
  output logic                   xxNew,
  output logic                   fxNew,
  output logic                   trapUnavail
);
  i2dPkg::ctlStrobe_t strobe;
  logic [LANES-1:0]   laneInexact;

  i2dControl #(.LANES(LANES)) uCtl (
    .clk, .rstN, .start, .unitEn, .inexEn, .xxIn, .fxIn,
    .laneInexact, .strobe, .resWe, .flagWe, .xxNew, .fxNew, .trapUnavail
  );

  i2dDatapath #(.LANES(LANES), .INT_W(INT_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .clk, .rstN, .strobe, .rndMode, .srcVec, .laneInexact, .resultVec
  );
endmodule

// File: rtl/dualIntToDblChk.sv
module dualIntToDblChk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             unitEn,
  input logic             inexEn,
  input logic             xxIn,
  input logic             fxIn,
  input logic [VEC_W-1:0] srcVec,
  input logic [VEC_W-1:0] resultVec,
  input logic             resWe,
  input logic             flagWe,
  input logic             xxNew,
  input logic             fxNew,
  input logic             trapUnavail
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!resWe && !flagWe && !trapUnavail)); // R9
  AST_TRAP_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !unitEn) |=> (trapUnavail && !resWe && !flagWe)); // R8
  AST_TRAP_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    trapUnavail |-> $stable(resultVec)); // R8
  AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (start && unitEn && srcVec == '0) |=> (resultVec == '0 && xxNew == $past(xxIn))); // R3
  AST_XX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (start && unitEn && xxIn) |=> (xxNew && fxNew == $past(fxIn))); // R6
  AST_FX_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (start && unitEn && fxIn) |=> fxNew); // R6
  AST_FLAG_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (start && unitEn) |=> flagWe); // R5
  AST_WRITE_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (start && unitEn && !inexEn) |=> resWe); // R7
  AST_SUPPRESS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && xxNew && !$past(xxIn) && $past(inexEn)) |-> !resWe); // R7
endmodule

bind dualIntToDbl dualIntToDblChk #(.VEC_W(LANES*INT_W)) uChk (.*);

// File: tb/test_dualIntToDbl.sv
`timescale 1ns/1ps
module test_dualIntToDbl;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         unitEn = 1'b0;
  logic [1:0]   rndMode = 2'b00;
  logic         inexEn = 1'b0;
  logic         xxIn = 1'b0;
  logic         fxIn = 1'b0;
  logic [127:0] srcVec = '0;
  logic [127:0] resultVec;
  logic         resWe, flagWe, xxNew, fxNew, trapUnavail;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  logic [127:0] lastRes = '0;
  logic [63:0]  lfsr = 64'h9E37_79B9_7F4A_7C15;

  dualIntToDbl i_dualIntToDbl (
    .clk, .rstN, .start, .unitEn, .rndMode, .inexEn, .xxIn, .fxIn,
    .srcVec, .resultVec, .resWe, .flagWe, .xxNew, .fxNew, .trapUnavail
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  // arithmetic model: quotient and remainder against a power of two
  function automatic void refConv(input logic [63:0] x, input logic [1:0] rm,
                                  output logic [63:0] bits, output logic inex);
    logic sgn;
    logic [63:0] mag, q, rem, half;
    int msb, shift, e;
    logic up;
    sgn = x[63];
    mag = sgn ? (64'd0 - x) : x;
    inex = 1'b0;
    if (mag == 0) begin bits = '0; return; end
    msb = 0;
    for (int k = 0; k < 64; k++) if (mag[k]) msb = k;
    e = 1023 + msb;
    if (msb <= 52) begin
      q = mag << (52 - msb);
    end else begin
      shift = msb - 52;
      q     = mag >> shift;
      rem   = mag - (q << shift);
      half  = 64'd1 << (shift - 1);
      inex  = (rem != 0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b01:   up = 1'b0;
        2'b10:   up = inex && !sgn;
        default: up = inex && sgn;
      endcase
      q = q + 64'(up);
      if (q == (64'd1 << 53)) begin q = 64'd1 << 52; e++; end
    end
    bits = {sgn, e[10:0], q[51:0]};
  endfunction

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [1:0] rm,
                     input logic ie, input logic ue, input logic xx, input logic fx);
    logic [63:0] ra, rb;
    logic ia, ib, inex;
    @(negedge clk);
    srcVec = {b, a}; rndMode = rm; inexEn = ie; unitEn = ue;
    xxIn = xx; fxIn = fx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    refConv(a, rm, ra, ia);
    refConv(b, rm, rb, ib);
    inex = ia | ib;
    if (ue) begin
      lastRes = {rb, ra};
      check("R1/R2 result", resultVec, lastRes);
      check("R7 strobes", {125'd0, resWe, flagWe, trapUnavail},
            {125'd0, ~(ie & inex), 1'b1, 1'b0});
      check("R5 xx", {127'd0, xxNew}, {127'd0, xx | inex});
      check("R6 fx", {127'd0, fxNew}, {127'd0, fx | (inex & ~xx)});
    end else begin
      check("R8 strobes", {125'd0, resWe, flagWe, trapUnavail}, 128'd4 >> 2 | 128'd1);
      check("R8 result held", resultVec, lastRes);
    end
  endtask

  task automatic directed(input logic [63:0] a, input logic [1:0] rm,
                          input logic [63:0] exp, input string req);
    run(a, 64'd0, rm, 1'b0, 1'b1, 1'b0, 1'b0);
    check(req, {64'd0, resultVec[63:0]}, {64'd0, exp});
  endtask

  initial begin
    logic [63:0] a, b;
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset result", resultVec, '0);
    check("R10 reset strobes", {125'd0, resWe, flagWe, trapUnavail}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 after reset", {resultVec[126:0], resWe | flagWe | trapUnavail}, '0);

    // R3 and R4 directed corners
    directed(64'd0, 2'b00, 64'h0, "R3 zero");
    directed(64'h8000_0000_0000_0000, 2'b10, 64'hC3E0_0000_0000_0000, "R3 min int");
    directed(64'd1 << 53, 2'b01, 64'h4340_0000_0000_0000, "R3 2^53");
    directed(64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 64'hBFF0_0000_0000_0000, "R3 minus one");
    directed(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 64'h43E0_0000_0000_0000, "R4 carry");
    directed(64'h7FFF_FFFF_FFFF_FFFF, 2'b01, 64'h43DF_FFFF_FFFF_FFFF, "R4 truncate");
    directed((64'd1 << 53) + 64'd1, 2'b00, 64'h4340_0000_0000_0000, "R2 tie even down");
    directed((64'd1 << 53) + 64'd3, 2'b00, 64'h4340_0000_0000_0002, "R2 tie even up");

    // R1 R2 sweep around every power of two, all modes
    for (int rm = 0; rm < 4; rm++)
      for (int k = 0; k < 64; k++)
        for (int d = -2; d <= 2; d++) begin
          a = (64'd1 << k) + 64'(d);
          b = (d[0]) ? (64'd0 - a) : (nextRand() >> k);
          run(a, b, 2'(rm), 1'b0, 1'b1, k[0], k[1]);
        end

    // R7 enabled exception: inexact suppresses, exact writes
    for (int rm = 0; rm < 4; rm++) begin
      run((64'd1 << 53) + 64'd1, 64'd5, 2'(rm), 1'b1, 1'b1, 1'b0, 1'b0);
      run(64'd5, 64'd0 - ((64'd1 << 60) + 64'd7), 2'(rm), 1'b1, 1'b1, 1'b1, 1'b0);
      run(64'd12345, 64'h8000_0000_0000_0000, 2'(rm), 1'b1, 1'b1, 1'b0, 1'b1);
    end

    // R8 trap, then mixed random operation
    run(64'd77, 64'd99, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n < 600; n++) begin
      logic [63:0] r;
      r = nextRand();
      a = nextRand() >> r[5:0];
      b = nextRand() >> r[11:6];
      run(a, b, r[13:12], r[14], (r[19:16] != 0), r[20], r[21]);
    end

    // R9 idle cycles produce no strobes
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      check("R9 idle", {125'd0, resWe, flagWe, trapUnavail}, '0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule